// File: doc/BRIEF.md
# Interval Timer with Toggle Output

This block is a free-running interval timer built around an up-counter whose width is a parameter (16 bits by default). The counter advances only on cycles where a count-enable strobe is high. When a strobe arrives and the count equals the active compare value, the counter returns to zero, a one-cycle match interrupt is raised, and a toggle output inverts. Compare value D therefore gives one interrupt every D + 1 strobes, with a square wave of period 2(D + 1) strobes on the toggle output.

Software loads the compare value through a single-cycle write strobe. A write reaches the active compare register at the next clock edge, with no wait for the end of the current period. Raising the value stretches the period in progress. Lowering it below the current count makes the counter run on to all ones, wrap to zero and then climb to the new value, which gives one long interval. A run-enable input gates the timer. While it is low, the counter is held at zero and the toggle output sits at the level chosen by the initial-level input.

Top module: `interval_toggle_timer`

## Requirements
- R1: After reset the compare value is all ones (FFFFH), the counter is zero and the interrupt is low, so the first interrupt after starting comes after 65536 strobes.
- R2: The counter advances only on cycles where cnt_en is high, and a match is only detected on such cycles.
- R3: With compare value D held constant, consecutive interrupts are D + 1 strobes apart.
- R4: The interrupt is high for exactly the one cycle after the clock edge at which the matching strobe was sampled.
- R5: The toggle output inverts at the same edge that raises the interrupt, and at no other edge while running with a steady init_level.
- R6: The toggle output equals init_level while run_en is low. Counting starts from that level.
- R7: Clearing run_en returns the counter to zero and suppresses the interrupt, so a restart gives a full first period of D + 1 strobes.
- R8: A compare write takes effect at the next edge. Raising the value mid-count lengthens the current interval to the new D + 1.
- R9: Writing a value D below the current count makes the counter pass through all ones and wrap, so that interval is 10000H + D + 1 strobes.
- R10: When a write and a match fall on the same edge, the match uses the old value and the new value governs the following interval.
- R11: Compare writes are accepted while run_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer run enable; low holds counter at zero |
| cnt_en | input | 1 | Count strobe; counter steps on cycles where it is high |
| init_level | input | 1 | Toggle output level while stopped and at start |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | New compare value |
| tout | output | 1 | Toggle output |
| match_irq | output | 1 | One-cycle compare-match interrupt |

## Verification
A corrupted count or compare value has no port of its own. It shows up as an interrupt that is early or late against the strobe count, often by a whole wrap of 65536 strobes. A wrong toggle phase shows on tout at the next match or stop. The bench models the timer cycle by cycle and compares both outputs on every cycle, so a divergence is reported at the first edge where it reaches a port. Directed interval measurements tie each mismatch to the requirement it breaks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   // What the counter does at the next edge
   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_INC   = 2'd1,
      STEP_CLEAR = 2'd2
   } step_e;

   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 32;

endpackage

// File: rtl/itmr_cmp_reg.sv
module itmr_cmp_reg #(
   parameter int unsigned       CNT_W   = 16,
   parameter logic [CNT_W-1:0]  CMP_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cmp_q
);

   // Immediate load: no shadow, no deferral to a period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cmp_q <= CMP_RST;
      else if (wr) cmp_q <= wdata;
   end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
   import itmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             strobe,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   step_e step;
   logic  equal;

   assign equal = (cnt_q == cmp);
   assign hit   = run && strobe && equal;

   always_comb begin
      if (!run)        step = STEP_CLEAR;
      else if (!strobe) step = STEP_HOLD;
      else if (equal)  step = STEP_CLEAR;
      else             step = STEP_INC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (step)
            STEP_CLEAR: cnt_q <= '0;
            STEP_INC:   cnt_q <= cnt_q + ONE;
            default:    cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/itmr_toggle.sv
module itmr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hit,
   input  logic init_level,
   output logic tout,
   output logic irq
);

   logic phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= hit;
         if (!run)     phase_q <= 1'b0;
         else if (hit) phase_q <= ~phase_q;
      end
   end

   // Phase is relative to the initial level, so a stopped timer shows it directly
   assign tout = init_level ^ phase_q;

endmodule

// File: rtl/interval_toggle_timer.sv
module interval_toggle_timer
   import itmr_pkg::*;
#(
   parameter int unsigned       CNT_W   = 16,
   parameter logic [CNT_W-1:0]  CMP_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             cnt_en,
   input  logic             init_level,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   output logic             tout,
   output logic             match_irq
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("interval_toggle_timer: CNT_W out of supported range");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] cnt_val;
   logic             hit;

   itmr_cmp_reg #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr),
      .wdata (cmp_wdata),
      .cmp_q (cmp_val)
   );

   itmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_en),
      .strobe (cnt_en),
      .cmp    (cmp_val),
      .cnt_q  (cnt_val),
      .hit    (hit)
   );

   itmr_toggle u_tog (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_en),
      .hit        (hit),
      .init_level (init_level),
      .tout       (tout),
      .irq        (match_irq)
   );

endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             cnt_en,
   input logic             init_level,
   input logic             cmp_wr,
   input logic [CNT_W-1:0] cmp_wdata,
   input logic             tout,
   input logic             match_irq,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cmp_val
);

   // R2
   irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |-> $past(run_en && cnt_en));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && cnt_en && (cnt_val != cmp_val)) |=> (cnt_val == $past(cnt_val) + 1'b1));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cnt_en) |=> $stable(cnt_val));

   // R5
   irq_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_irq && $stable(init_level)) |-> (tout != $past(tout)));

   // R5
   no_stray_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en) && $stable(init_level) && !match_irq) |-> $stable(tout));

   // R7
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!match_irq && (cnt_val == '0)));

   // R6
   stopped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (tout == init_level));

   // R8
   write_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> (cmp_val == $past(cmp_wdata)));

endmodule

bind interval_toggle_timer itmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en     (run_en),
   .cnt_en     (cnt_en),
   .init_level (init_level),
   .cmp_wr     (cmp_wr),
   .cmp_wdata  (cmp_wdata),
   .tout       (tout),
   .match_irq  (match_irq),
   .cnt_val    (cnt_val),
   .cmp_val    (cmp_val)
);

// File: tb/interval_toggle_timer_test.sv
`timescale 1ns/1ps
module interval_toggle_timer_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_en = 1'b0;
   logic         cnt_en = 1'b0;
   logic         init_level = 1'b1;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         tout;
   logic         match_irq;

   interval_toggle_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en),
      .init_level(init_level), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .tout(tout), .match_irq(match_irq)
   );

   always #2 clk = ~clk;

   int nvec = 0;
   int nbad = 0;
   string cur_req = "R4";

   // reference state from the requirements
   logic [W-1:0] m_cnt, m_cmp;
   logic         m_ph, m_irq;
   int           since = 0;
   int           last_gap = 0;
   bit           got_irq = 0;

   task automatic check(string req, string what, longint act, longint exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   function automatic logic next_irq();
      return run_en && cnt_en && (m_cnt == m_cmp);
   endfunction

   task automatic tick();
      logic hit;
      hit = next_irq();
      if (run_en && cnt_en) since++;
      @(posedge clk);
      m_irq = hit;
      if (!run_en) begin
         m_cnt = '0; m_ph = 1'b0;
      end else if (cnt_en) begin
         if (hit) begin m_cnt = '0; m_ph = ~m_ph; end
         else m_cnt = m_cnt + 1'b1;
      end
      if (cmp_wr) m_cmp = cmp_wdata;
      @(negedge clk);
      check(cur_req, "match_irq", match_irq, m_irq);
      check(cur_req, "tout", tout, init_level ^ m_ph);
      if (match_irq) begin last_gap = since; since = 0; got_irq = 1; end
      if (!run_en) since = 0;
   endtask

   task automatic until_irq(int limit, int per);
      got_irq = 0;
      for (int i = 0; i < limit && !got_irq; i++) begin
         cnt_en = ((i % per) == 0);
         tick();
      end
      cnt_en = 1'b0;
      check(cur_req, "irq seen", got_irq, 1);
   endtask

   task automatic strobes(int n);
      cnt_en = 1'b1;
      for (int i = 0; i < n; i++) tick();
      cnt_en = 1'b0;
   endtask

   task automatic write_cmp(logic [W-1:0] v, logic en);
      cmp_wr = 1'b1; cmp_wdata = v; cnt_en = en;
      tick();
      cmp_wr = 1'b0; cnt_en = 1'b0;
   endtask

   task automatic stop_start(logic [W-1:0] v);
      run_en = 1'b0; tick();
      write_cmp(v, 1'b0);
      run_en = 1'b1;
   endtask

   initial begin
      #760000;
      nbad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      m_cnt = '0; m_cmp = '1; m_ph = 1'b0; m_irq = 1'b0;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1", "irq at reset", match_irq, 0);
      check("R6", "tout at reset", tout, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: stopped timer ignores strobes and shows init level
      cur_req = "R6";
      strobes(5);
      init_level = 1'b0; tick();
      check("R6", "tout follows init while stopped", tout, 0);
      init_level = 1'b1; tick();

      // R1: reset compare of FFFFH
      cur_req = "R1";
      run_en = 1'b1;
      until_irq(70000, 1);
      check("R1", "first interval", last_gap, 65536);
      check("R5", "tout inverted", tout, 0);

      // R7/R11: stop, write while stopped, restart
      cur_req = "R7";
      run_en = 1'b0; tick();
      check("R7", "tout back to init", tout, 1);
      check("R7", "irq low when stopped", match_irq, 0);
      write_cmp(16'd9, 1'b1);
      run_en = 1'b1;
      until_irq(100, 1);
      check("R11", "interval after stopped write", last_gap, 10);
      cur_req = "R3";
      until_irq(100, 1);
      check("R3", "steady interval", last_gap, 10);
      check("R5", "tout after two matches", tout, 1);

      // R2: sparse strobes
      cur_req = "R2";
      stop_start(16'd4);
      until_irq(100, 3);
      check("R2", "strobes per interval", last_gap, 5);
      until_irq(100, 7);
      check("R2", "strobes per interval sparse", last_gap, 5);

      // R8: raise compare mid-count
      cur_req = "R8";
      stop_start(16'd20);
      until_irq(100, 1);
      check("R8", "base interval", last_gap, 21);
      strobes(5);
      write_cmp(16'd40, 1'b1);
      until_irq(100, 1);
      check("R8", "stretched interval", last_gap, 41);

      // R9: lower compare below count
      cur_req = "R9";
      stop_start(16'd100);
      until_irq(200, 1);
      check("R9", "base interval", last_gap, 101);
      strobes(50);
      write_cmp(16'd10, 1'b1);
      until_irq(70000, 1);
      check("R9", "wrap interval", last_gap, 32'h10000 + 10 + 1);
      until_irq(100, 1);
      check("R9", "interval after wrap", last_gap, 11);

      // R10: write on the matching strobe
      cur_req = "R10";
      stop_start(16'd7);
      until_irq(100, 1);
      strobes(7);
      got_irq = 0;
      write_cmp(16'd3, 1'b1);
      check("R10", "match on old value", got_irq, 1);
      check("R10", "old interval", last_gap, 8);
      until_irq(100, 1);
      check("R10", "new interval", last_gap, 4);

      // R4: constrained random mix
      cur_req = "R4";
      for (int i = 0; i < 3000; i++) begin
         cnt_en = $urandom_range(1, 0) == 1;
         if ($urandom_range(199, 0) == 0) run_en = ~run_en;
         if ($urandom_range(299, 0) == 0) init_level = ~init_level;
         cmp_wr = ($urandom_range(49, 0) == 0);
         cmp_wdata = W'($urandom_range(63, 0));
         tick();
      end
      cmp_wr = 1'b0; cnt_en = 1'b0;
      tick();
      summary();
   end

endmodule